// File: doc/BRIEF.md
# Dual-Half Multiply-Accumulate Unit

This block decodes and executes a family of 16x16 multiply and multiply-accumulate instructions carried in a 24-bit instruction word. Each instruction takes one 16-bit half from each of two 32-bit operands. An operand is either a general-register value, which the surrounding core supplies on an input port, or one of four local 32-bit operand registers. The signed or unsigned product either replaces a 40-bit accumulator or is added to it or subtracted from it. The accumulator is presented as a 32-bit low word and an 8-bit high word.

Some instruction forms also write a 32-bit word, delivered by the core's load path, into one operand register. The multiply in such a fused form still uses the operand values from before the load. The block does not generate addresses. It only reports, one cycle after the strobe, whether the base register should step up or down. Any word the block does not own, or whose reserved fields are not zero, is flagged as foreign and changes no state.

Top module: `mac16_unit`

## Requirements
- R1: Word fields from the top bit down: op2 = insn[23:20], op1 = insn[19:16], r = insn[15:12], s = insn[11:8], t = insn[7:4], op0 = insn[3:0]. Only op0 = 4 belongs to the unit. Any other strobed word sets foreign_o for one cycle and leaves the accumulator and the operand registers unchanged. The same holds for any op2 value not listed in R4, R6 or R7.
- R2: op1[3:2] selects the operation. 00 is an unsigned product that replaces the accumulator. 01 is a signed product that replaces it. 10 adds a signed product to it. 11 subtracts a signed product from it. The replacing forms never depend on the old accumulator value.
- R3: op1[0]=1 takes the upper half of the first operand, and 0 takes the lower half. op1[1] selects the half of the second operand in the same way.
- R4: op2 selects the operand sources. 7 is gpr_s x gpr_t. 3 is gpr_s x operand register (2 + t[2]). 6 is operand register r[2] x gpr_t. 2 is operand register r[2] x operand register (2 + t[2]).
- R5: Signed forms sign-extend each half and the product to 40 bits. Unsigned products are zero-extended. Add and subtract wrap modulo 2^40.
- R6: op2 5 and 4 (register x gpr_t) and op2 1 and 0 (register x register) are fused forms. They are legal only with op1[3:2] = 10, and with any other value they are foreign. Each one accumulates and also writes ld_data into operand register r[1:0]. The product uses the register values from before the write, and the new value is seen from the next instruction on.
- R7: op1 = 0 with op2 = 9 or 8 writes ld_data into operand register r[1:0] and leaves the accumulator unchanged. With any other op1 value, op2 9 and 8 are foreign.
- R8: One cycle after a legal load-carrying word (R6, R7), upd_req_o is 1. upd_dec_o is 1 for op2 5, 1 and 9 (decrement) and 0 for op2 4, 0 and 8 (increment). Both outputs are 0 after every other word.
- R9: Results and flags appear on the first rising edge after the strobe, and not before it. Without insn_valid, the accumulator holds and every flag is 0.
- R10: Synchronous reset clears the accumulator, all four operand registers and all flags.
- R11: Reserved fields must be zero, otherwise the word is foreign. The fields are: r for op2 7 and 3; t[3] and t[1:0] for op2 3, 2, 1 and 0; s, r[3] and r[1:0] for op2 6 and 2; r[3] for op2 5, 4, 1 and 0; r[3:2] and t for op2 9 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Strobe: insn and the operand ports are valid this cycle |
| insn | input | 24 | Instruction word |
| gpr_s | input | 32 | General-register value named by the s field (first operand) |
| gpr_t | input | 32 | General-register value named by the t field (second operand) |
| ld_data | input | 32 | Loaded word for the load-carrying forms |
| acc_lo_o | output | 32 | Accumulator bits 31:0 |
| acc_hi_o | output | 8 | Accumulator bits 39:32 |
| foreign_o | output | 1 | Previous strobed word was not executed |
| upd_req_o | output | 1 | Base-register update requested |
| upd_dec_o | output | 1 | Requested update is a decrement |

## Verification
The bench builds the unit with its default parameters: 32-bit operands, 16-bit halves and a 40-bit accumulator. With these defaults, the 8 guard bits can be filled and wrapped by a single subtract or add, so sign extension and modulo-2^40 behaviour are tested directly, not only through long runs. The halves reach their extreme values, such as 0x8000 x 0x8000 and 0xFFFF x 0xFFFF. A reference model follows the operand registers through fused loads, which shows whether a product used the old or the new register value.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

  localparam int INSN_W   = 24;
  localparam int MR_IDX_W = 2;
  localparam int MR_COUNT = 1 << MR_IDX_W;

  localparam logic [3:0] UNIT_OP0 = 4'd4;

  // op2 source / form codes
  localparam logic [3:0] F_GG     = 4'd7;
  localparam logic [3:0] F_GM     = 4'd3;
  localparam logic [3:0] F_MG     = 4'd6;
  localparam logic [3:0] F_MM     = 4'd2;
  localparam logic [3:0] F_MG_DEC = 4'd5;
  localparam logic [3:0] F_MG_INC = 4'd4;
  localparam logic [3:0] F_MM_DEC = 4'd1;
  localparam logic [3:0] F_MM_INC = 4'd0;
  localparam logic [3:0] F_LD_DEC = 4'd9;
  localparam logic [3:0] F_LD_INC = 4'd8;

  typedef enum logic [1:0] {
    ACC_SET_U = 2'b00,
    ACC_SET_S = 2'b01,
    ACC_ADD   = 2'b10,
    ACC_SUB   = 2'b11
  } acc_op_e;

  typedef struct packed {
    logic [3:0] op2;
    logic [3:0] op1;
    logic [3:0] r;
    logic [3:0] s;
    logic [3:0] t;
    logic [3:0] op0;
  } insn_t;

  typedef struct packed {
    logic                recog;
    logic                do_mac;
    acc_op_e             op;
    logic                x_hi;
    logic                y_hi;
    logic                x_gpr;
    logic                y_gpr;
    logic [MR_IDX_W-1:0] x_idx;
    logic [MR_IDX_W-1:0] y_idx;
    logic                do_load;
    logic [MR_IDX_W-1:0] ld_idx;
    logic                upd;
    logic                dec;
  } mac_ctl_t;

endpackage

// File: rtl/mac16_decode.sv
module mac16_decode
  import mac16_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mac_ctl_t          ctl
);

  insn_t f;
  logic  form_ok;
  logic  rsv_ok;

  assign f = insn_t'(insn);

  always_comb begin
    ctl       = '0;
    form_ok   = 1'b0;
    rsv_ok    = 1'b0;
    // R2 / R3: operation and half selection come from op1
    ctl.op    = acc_op_e'(f.op1[3:2]);
    ctl.x_hi  = f.op1[0];
    ctl.y_hi  = f.op1[1];
    // R4: first register from {0,r[2]}, second from {1,t[2]}
    ctl.x_idx = {1'b0, f.r[2]};
    ctl.y_idx = {1'b1, f.t[2]};
    ctl.ld_idx = f.r[1:0];

    case (f.op2)
      F_GG: begin
        form_ok    = 1'b1;
        ctl.do_mac = 1'b1;
        ctl.x_gpr  = 1'b1;
        ctl.y_gpr  = 1'b1;
        rsv_ok     = (f.r == 4'd0);
      end
      F_GM: begin
        form_ok    = 1'b1;
        ctl.do_mac = 1'b1;
        ctl.x_gpr  = 1'b1;
        rsv_ok     = (f.r == 4'd0) && !f.t[3] && (f.t[1:0] == 2'd0);
      end
      F_MG: begin
        form_ok    = 1'b1;
        ctl.do_mac = 1'b1;
        ctl.y_gpr  = 1'b1;
        rsv_ok     = (f.s == 4'd0) && !f.r[3] && (f.r[1:0] == 2'd0);
      end
      F_MM: begin
        form_ok    = 1'b1;
        ctl.do_mac = 1'b1;
        rsv_ok     = (f.s == 4'd0) && !f.r[3] && (f.r[1:0] == 2'd0)
                     && !f.t[3] && (f.t[1:0] == 2'd0);
      end
      // R6: fused accumulate + load, register x general register
      F_MG_DEC, F_MG_INC: begin
        form_ok     = (f.op1[3:2] == 2'b10);
        ctl.do_mac  = 1'b1;
        ctl.y_gpr   = 1'b1;
        ctl.do_load = 1'b1;
        ctl.upd     = 1'b1;
        ctl.dec     = (f.op2 == F_MG_DEC);
        rsv_ok      = !f.r[3];
      end
      // R6: fused accumulate + load, register x register
      F_MM_DEC, F_MM_INC: begin
        form_ok     = (f.op1[3:2] == 2'b10);
        ctl.do_mac  = 1'b1;
        ctl.do_load = 1'b1;
        ctl.upd     = 1'b1;
        ctl.dec     = (f.op2 == F_MM_DEC);
        rsv_ok      = !f.r[3] && !f.t[3] && (f.t[1:0] == 2'd0);
      end
      // R7: pure operand-register load
      F_LD_DEC, F_LD_INC: begin
        form_ok     = (f.op1 == 4'd0);
        ctl.do_load = 1'b1;
        ctl.upd     = 1'b1;
        ctl.dec     = (f.op2 == F_LD_DEC);
        rsv_ok      = (f.r[3:2] == 2'd0) && (f.t == 4'd0);
      end
      default: ;
    endcase

    // R1 / R11: anything not owned or with nonzero reserved bits is foreign
    ctl.recog = (f.op0 == UNIT_OP0) && form_ok && rsv_ok;
    if (!ctl.recog) begin
      ctl.do_mac  = 1'b0;
      ctl.do_load = 1'b0;
      ctl.upd     = 1'b0;
      ctl.dec     = 1'b0;
    end
  end

endmodule

// File: rtl/mac16_opregs.sv
module mac16_opregs
  import mac16_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [MR_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [MR_IDX_W-1:0] x_idx,
  input  logic [MR_IDX_W-1:0] y_idx,
  output logic [DATA_W-1:0]   x_q,
  output logic [DATA_W-1:0]   y_q
);

  logic [DATA_W-1:0] mr [MR_COUNT];

  // R10 clear; R6/R7 write takes effect at the edge, so reads this cycle see old data
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MR_COUNT; i++) mr[i] <= '0;
    end else if (wr_en) begin
      mr[wr_idx] <= wr_data;
    end
  end

  assign x_q = mr[x_idx];
  assign y_q = mr[y_idx];

endmodule

// File: rtl/mac16_datapath.sv
module mac16_datapath
  import mac16_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [DATA_W-1:0] x_w,
  input  logic [DATA_W-1:0] y_w,
  input  logic              x_hi,
  input  logic              y_hi,
  input  acc_op_e           op,
  input  logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  acc_d
);

  localparam int PROD_W = 2 * HALF_W + 2;
  localparam int PAD_W  = ACC_W - PROD_W;

  logic [HALF_W-1:0]        hx, hy;
  logic                     sg;
  logic signed [HALF_W:0]   ex, ey;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_ext;

  // R3: half selection
  assign hx = x_hi ? x_w[2*HALF_W-1:HALF_W] : x_w[HALF_W-1:0];
  assign hy = y_hi ? y_w[2*HALF_W-1:HALF_W] : y_w[HALF_W-1:0];

  // R5: one 17x17 signed multiplier serves both signed and unsigned forms
  assign sg   = (op != ACC_SET_U);
  assign ex   = {sg & hx[HALF_W-1], hx};
  assign ey   = {sg & hy[HALF_W-1], hy};
  assign prod = PROD_W'(ex) * PROD_W'(ey);

  generate
    if (PAD_W > 0) begin : g_pad
      assign prod_ext = {{PAD_W{prod[PROD_W-1]}}, prod};
    end else begin : g_trim
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  // R2: replacing forms never look at acc_q; R5: add/sub wrap at ACC_W bits
  always_comb begin
    case (op)
      ACC_ADD: acc_d = acc_q + prod_ext;
      ACC_SUB: acc_d = acc_q - prod_ext;
      default: acc_d = prod_ext;
    endcase
  end

endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
  import mac16_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                insn_valid,
  input  logic [INSN_W-1:0]   insn,
  input  logic [DATA_W-1:0]   gpr_s,
  input  logic [DATA_W-1:0]   gpr_t,
  input  logic [DATA_W-1:0]   ld_data,
  output logic [DATA_W-1:0]   acc_lo_o,
  output logic [ACC_W-DATA_W-1:0] acc_hi_o,
  output logic                foreign_o,
  output logic                upd_req_o,
  output logic                upd_dec_o
);

  mac_ctl_t          ctl;
  logic [DATA_W-1:0] x_mr, y_mr;
  logic [DATA_W-1:0] x_op, y_op;
  logic [ACC_W-1:0]  acc_q, acc_d;

  mac16_decode u_dec (
    .insn (insn),
    .ctl  (ctl)
  );

  mac16_opregs #(.DATA_W(DATA_W)) u_mr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (insn_valid && ctl.do_load),
    .wr_idx  (ctl.ld_idx),
    .wr_data (ld_data),
    .x_idx   (ctl.x_idx),
    .y_idx   (ctl.y_idx),
    .x_q     (x_mr),
    .y_q     (y_mr)
  );

  // R4: operand routing
  assign x_op = ctl.x_gpr ? gpr_s : x_mr;
  assign y_op = ctl.y_gpr ? gpr_t : y_mr;

  mac16_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_dp (
    .x_w   (x_op),
    .y_w   (y_op),
    .x_hi  (ctl.x_hi),
    .y_hi  (ctl.y_hi),
    .op    (ctl.op),
    .acc_q (acc_q),
    .acc_d (acc_d)
  );

  // R8 / R9 / R10: registered results and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      foreign_o <= 1'b0;
      upd_req_o <= 1'b0;
      upd_dec_o <= 1'b0;
    end else begin
      foreign_o <= insn_valid && !ctl.recog;
      upd_req_o <= insn_valid && ctl.upd;
      upd_dec_o <= insn_valid && ctl.dec;
      if (insn_valid && ctl.do_mac) acc_q <= acc_d;
    end
  end

  assign acc_lo_o = acc_q[DATA_W-1:0];
  assign acc_hi_o = acc_q[ACC_W-1:DATA_W];

endmodule

// File: rtl/mac16_unit_chk.sv
module mac16_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    insn_valid,
  input logic [23:0]             insn,
  input logic [DATA_W-1:0]       acc_lo_o,
  input logic [ACC_W-DATA_W-1:0] acc_hi_o,
  input logic                    foreign_o,
  input logic                    upd_req_o,
  input logic                    upd_dec_o
);

  localparam int HI_W = ACC_W - DATA_W;

  logic plain_src;
  assign plain_src = (insn[23:20] == 4'd7) || (insn[23:20] == 4'd3) ||
                     (insn[23:20] == 4'd6) || (insn[23:20] == 4'd2);

  a_r1_foreign_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn[3:0] != 4'd4) |=>
      (foreign_o && !upd_req_o && $stable(acc_lo_o) && $stable(acc_hi_o)));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=>
      (!foreign_o && !upd_req_o && !upd_dec_o && $stable(acc_lo_o) && $stable(acc_hi_o)));

  a_r2_unsigned_hi_clear: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn[3:0] == 4'd4 && plain_src && insn[19:18] == 2'b00) |=>
      (foreign_o || acc_hi_o == '0));

  a_r5_signed_hi_extends: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn[3:0] == 4'd4 && plain_src && insn[19:18] == 2'b01) |=>
      (foreign_o || acc_hi_o == {HI_W{acc_lo_o[DATA_W-1]}}));

  a_r7_load_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn[3:0] == 4'd4 && insn[19:16] == 4'd0 && insn[23:21] == 3'b100) |=>
      (foreign_o || (upd_req_o && upd_dec_o == $past(insn[20]) &&
                     $stable(acc_lo_o) && $stable(acc_hi_o))));

  a_r8_dec_implies_req: assert property (@(posedge clk) disable iff (rst)
    upd_dec_o |-> upd_req_o);

endmodule

bind mac16_unit mac16_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .insn_valid (insn_valid),
  .insn       (insn),
  .acc_lo_o   (acc_lo_o),
  .acc_hi_o   (acc_hi_o),
  .foreign_o  (foreign_o),
  .upd_req_o  (upd_req_o),
  .upd_dec_o  (upd_dec_o)
);

// File: tb/mac16_unit_test.sv
module mac16_unit_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ld;
    logic        ef;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{24'h580374, 32'h0, 32'h0003_0002, 32'h0000_0005, 1'b0, 4'd6},  // R6 dec, old mr0
    '{24'h4B5214, 32'h0, 32'hFFFF_0001, 32'hABCD_0010, 1'b0, 4'd6},  // R6 inc HH
    '{24'h196044, 32'h0, 32'h0,         32'h0002_0002, 1'b0, 4'd6},  // R6 reg x reg dec
    '{24'h0A3104, 32'h0, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd6},  // R6 reg x reg inc
    '{24'h240044, 32'h0, 32'h0,         32'h0,         1'b0, 4'd6},  // R6 new value visible
    '{24'h540374, 32'h0, 32'h1,         32'hDEAD_0000, 1'b1, 4'd6},  // R6 illegal op1
    '{24'h600064, 32'h0, 32'h1,         32'h0,         1'b0, 4'd6},  // R6 mr0 untouched
    '{24'h810004, 32'h0, 32'h0,         32'hDEAD_BEEF, 1'b1, 4'd7},  // R7 op1 nonzero
    '{24'h700005, 32'h5, 32'h5,         32'h0,         1'b1, 4'd1},  // R1 other op0
    '{24'hA00004, 32'h5, 32'h5,         32'h0,         1'b1, 4'd1},  // R1 unused op2
    '{24'h701004, 32'h5, 32'h5,         32'h0,         1'b1, 4'd11}, // R11 r nonzero
    '{24'h200104, 32'h0, 32'h0,         32'h0,         1'b1, 4'd11}, // R11 s nonzero
    '{24'h600064, 32'h0, 32'h1,         32'h0,         1'b0, 4'd7}   // R7 mr0 untouched
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [23:0] insn = '0;
  logic [31:0] gpr_s = '0;
  logic [31:0] gpr_t = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] acc_lo_o;
  logic [7:0]  acc_hi_o;
  logic        foreign_o, upd_req_o, upd_dec_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_mr [4];
  logic [39:0] m_acc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mac16_unit uut (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn       (insn),
    .gpr_s      (gpr_s),
    .gpr_t      (gpr_t),
    .ld_data    (ld_data),
    .acc_lo_o   (acc_lo_o),
    .acc_hi_o   (acc_hi_o),
    .foreign_o  (foreign_o),
    .upd_req_o  (upd_req_o),
    .upd_dec_o  (upd_dec_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [3:0] op2, input logic [3:0] op1,
                                     input logic [3:0] r, input logic [3:0] s,
                                     input logic [3:0] t);
    return {op2, op1, r, s, t, 4'd4};
  endfunction

  // Reference model built from R1..R11; checks acc and flags one edge after the strobe
  task automatic run(input logic [23:0] ins, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] ld, input string req);
    logic [3:0]  op0, t, s, r, op1, op2;
    logic        fok, rok, mac, ldo, dec, rec;
    logic [31:0] x, y;
    logic [15:0] hx, hy;
    logic [63:0] px, py;
    logic [39:0] p, e_acc;
    {op2, op1, r, s, t, op0} = ins;
    fok = 0; rok = 0; mac = 0; ldo = 0; dec = 0;
    case (op2)
      4'd7: begin fok = 1; mac = 1; rok = (r == 0); end
      4'd3: begin fok = 1; mac = 1; rok = (r == 0) && !t[3] && (t[1:0] == 0); end
      4'd6: begin fok = 1; mac = 1; rok = (s == 0) && !r[3] && (r[1:0] == 0); end
      4'd2: begin
        fok = 1; mac = 1;
        rok = (s == 0) && !r[3] && (r[1:0] == 0) && !t[3] && (t[1:0] == 0);
      end
      4'd5, 4'd4: begin
        fok = (op1[3:2] == 2'b10); mac = 1; ldo = 1; dec = (op2 == 4'd5); rok = !r[3];
      end
      4'd1, 4'd0: begin
        fok = (op1[3:2] == 2'b10); mac = 1; ldo = 1; dec = (op2 == 4'd1);
        rok = !r[3] && !t[3] && (t[1:0] == 0);
      end
      4'd9, 4'd8: begin
        fok = (op1 == 0); ldo = 1; dec = (op2 == 4'd9); rok = (r[3:2] == 0) && (t == 0);
      end
      default: ;
    endcase
    rec = (op0 == 4'd4) && fok && rok;
    x  = (op2 == 4'd7 || op2 == 4'd3) ? a : m_mr[{1'b0, r[2]}];
    y  = (op2 == 4'd7 || op2 == 4'd6 || op2 == 4'd5 || op2 == 4'd4) ? b : m_mr[{1'b1, t[2]}];
    hx = op1[0] ? x[31:16] : x[15:0];
    hy = op1[1] ? y[31:16] : y[15:0];
    if (op1[3:2] != 2'b00) begin
      px = {{48{hx[15]}}, hx};
      py = {{48{hy[15]}}, hy};
    end else begin
      px = {48'd0, hx};
      py = {48'd0, hy};
    end
    p = 40'(px * py);
    e_acc = m_acc;
    if (rec && mac) begin
      case (op1[3:2])
        2'b10:   e_acc = m_acc + p;
        2'b11:   e_acc = m_acc - p;
        default: e_acc = p;
      endcase
    end

    @(negedge clk);
    insn = ins; gpr_s = a; gpr_t = b; ld_data = ld; insn_valid = 1'b1;
    #1;
    check("R9", "acc before edge", 64'({acc_hi_o, acc_lo_o}), 64'(m_acc));
    @(negedge clk);
    insn_valid = 1'b0;
    check(req, "acc_lo", 64'(acc_lo_o), 64'(e_acc[31:0]));
    check(req, "acc_hi", 64'(acc_hi_o), 64'(e_acc[39:32]));
    check(req, "foreign", 64'(foreign_o), 64'(!rec));
    check("R8", "upd_req", 64'(upd_req_o), 64'(rec && ldo));
    check("R8", "upd_dec", 64'(upd_dec_o), 64'(rec && ldo && dec));
    if (rec && ldo) m_mr[r[1:0]] = ld;
    m_acc = e_acc;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    m_acc = '0;
    for (int i = 0; i < 4; i++) m_mr[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check("R10", "acc_lo", 64'(acc_lo_o), 64'd0);
    check("R10", "acc_hi", 64'(acc_hi_o), 64'd0);
    check("R10", "flags", 64'({foreign_o, upd_req_o, upd_dec_o}), 64'd0);
    // R10: operand registers cleared (unsigned HH of reg0 x reg2)
    run(mk(4'd2, 4'd3, 4'd0, 4'd0, 4'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R10");

    // R7: fill the four operand registers, both directions
    run(mk(4'd8, 4'd0, 4'd0, 4'd1, 4'd0), 32'h0, 32'h0, 32'h8000_7FFF, "R7");
    run(mk(4'd9, 4'd0, 4'd1, 4'd1, 4'd0), 32'h0, 32'h0, 32'h1234_FFFE, "R7");
    run(mk(4'd8, 4'd0, 4'd2, 4'd1, 4'd0), 32'h0, 32'h0, 32'hFFFF_8000, "R7");
    run(mk(4'd9, 4'd0, 4'd3, 4'd1, 4'd0), 32'h0, 32'h0, 32'h7FFF_0003, "R7");

    // R2 R3 R4 R5: all 16 op1 codes over all four plain source forms
    for (int i = 0; i < 64; i++) begin
      logic [3:0]  op2, r, s, t;
      logic        xs, ys;
      logic [31:0] a, b;
      xs = i[1] ^ i[4];
      ys = i[0] ^ i[5];
      case (i[5:4])
        2'd0: begin op2 = 4'd7; r = 4'd0; s = 4'd5; t = 4'd6; end
        2'd1: begin op2 = 4'd3; r = 4'd0; s = 4'd5; t = {1'b0, ys, 2'b00}; end
        2'd2: begin op2 = 4'd6; r = {1'b0, xs, 2'b00}; s = 4'd0; t = 4'd6; end
        default: begin op2 = 4'd2; r = {1'b0, xs, 2'b00}; s = 4'd0; t = {1'b0, ys, 2'b00}; end
      endcase
      a = 32'(i * 32'h9E37_79B1 + 32'h1357);
      b = {a[15:0] ^ 16'hA5A5, a[31:16] + 16'd77};
      if (i % 8 == 5) begin a = 32'h8000_8000; b = 32'h8000_FFFF; end
      run(mk(op2, 4'(i), r, s, t), a, b, 32'hCAFE_0000, "R2 R3 R4 R5");
    end

    // R6 R7 R1 R11: directed table
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      run(VECS[i].ins, VECS[i].a, VECS[i].b, VECS[i].ld, tag);
      check(tag, "table foreign", 64'(foreign_o), 64'(VECS[i].ef));
    end

    // R5: subtract from zero wraps into the guard byte
    run(mk(4'd7, 4'd0, 4'd0, 4'd1, 4'd2), 32'h0, 32'h0, 32'h0, "R2");
    run(mk(4'd7, 4'd12, 4'd0, 4'd1, 4'd2), 32'h0000_7FFF, 32'h0000_7FFF, 32'h0, "R5");
    check("R5", "sub wrap hi", 64'(acc_hi_o), 64'hFF);
    check("R5", "sub wrap lo", 64'(acc_lo_o), 64'hC000_FFFF);
    // R5: most negative squared, signed replace
    run(mk(4'd7, 4'd7, 4'd0, 4'd1, 4'd2), 32'h8000_0000, 32'h8000_0000, 32'h0, "R5");
    check("R5", "min squared", 64'({acc_hi_o, acc_lo_o}), 64'h00_4000_0000);
    // R2: unsigned all-ones
    run(mk(4'd7, 4'd3, 4'd0, 4'd1, 4'd2), 32'hFFFF_0000, 32'hFFFF_0000, 32'h0, "R2");
    check("R2", "unsigned max", 64'({acc_hi_o, acc_lo_o}), 64'h00_FFFE_0001);
    // R5: -1 then +1 wraps through 2^40
    run(mk(4'd7, 4'd0, 4'd0, 4'd1, 4'd2), 32'h0, 32'h0, 32'h0, "R2");
    run(mk(4'd7, 4'd12, 4'd0, 4'd1, 4'd2), 32'h1, 32'h1, 32'h0, "R5");
    check("R5", "minus one", 64'({acc_hi_o, acc_lo_o}), 64'hFF_FFFF_FFFF);
    run(mk(4'd7, 4'd8, 4'd0, 4'd1, 4'd2), 32'h1, 32'h1, 32'h0, "R5");
    check("R5", "wrap to zero", 64'({acc_hi_o, acc_lo_o}), 64'h0);

    // R9: no strobe, garbage on the inputs
    run(mk(4'd7, 4'd12, 4'd0, 4'd1, 4'd2), 32'h0000_0003, 32'h0000_0003, 32'h0, "R5");
    @(negedge clk);
    insn = mk(4'd7, 4'd8, 4'd0, 4'd0, 4'd0); gpr_s = 32'h7FFF_7FFF; gpr_t = 32'h7FFF_7FFF;
    ld_data = 32'h1;
    repeat (2) @(negedge clk);
    check("R9", "idle acc", 64'({acc_hi_o, acc_lo_o}), 64'(m_acc));
    check("R9", "idle flags", 64'({foreign_o, upd_req_o, upd_dec_o}), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule